// File: doc/BRIEF.md
# SPI Hold Pause Controller

This block sits between the serial pins of an SPI slave and the command framer that follows it. It handles the pause function of an active-low hold pin. It samples chip select, serial clock, data in and the hold pin into the system clock domain through one shared synchronizer. From these samples it produces single-cycle rising and falling clock strobes for the framer, a data bit aligned with each rising strobe, and a flag that forces the data-out driver to high impedance.

A pause starts or ends only while the serial clock is low. If the hold pin moves while the clock is high, the change takes effect when the clock next falls. While paused, the clock and data in are ignored. No strobe reaches the framer, so its bit counter and shift register stay frozen. The first rising clock edge after the pause is the next bit of the interrupted sequence. If chip select is raised during a pause, the block issues a one-cycle state-reset request. The framer then clears its command state and keeps its write-enable and write-busy flags.

Top module: `spi_hold_pause`

## Requirements
- R1: After reset, paused_o is 0, sdo_hiz_o is 1, and sck_rise_en_o, sck_fall_en_o and state_reset_o are 0.
- R2: With cs_n_i low and sck_i low, driving hold_n_i low sets paused_o to 1 within SYNC_STAGES+2 clock cycles.
- R3: If hold_n_i falls while sck_i is high, paused_o stays 0 until sck_i falls, and is then set. That falling clock edge produces no sck_fall_en_o strobe.
- R4: The pause ends when hold_n_i is high while sck_i is low. If hold_n_i rises while sck_i is high, paused_o stays 1 until sck_i falls. That falling edge produces no strobe.
- R5: While paused_o is 1, no sck_rise_en_o or sck_fall_en_o strobe is produced, whatever sck_i and sdi_i do. Bits taken before and after a pause join without loss or duplication: the captured byte equals the bits sent outside the pause, MSB first.
- R6: While cs_n_i is high, hold_n_i has no effect: paused_o stays 0.
- R7: Raising cs_n_i while paused gives exactly one state_reset_o pulse of one cycle and clears paused_o. Raising cs_n_i while not paused gives no pulse.
- R8: sdo_hiz_o is 1 whenever cs_n_i is high or paused_o is 1, and 0 otherwise.
- R9: Each rising sck_i edge taken while cs_n_i is low and the block is not paused gives exactly one sck_rise_en_o pulse. sdo_i carries the sdi_i level sampled at that edge. Each such falling edge gives one sck_fall_en_o pulse. The two strobes never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select pin, active low |
| sck_i | input | 1 | Serial clock pin |
| sdi_i | input | 1 | Serial data in pin |
| hold_n_i | input | 1 | Hold pin, active low |
| sck_rise_en_o | output | 1 | One-cycle strobe per accepted rising clock edge |
| sck_fall_en_o | output | 1 | One-cycle strobe per accepted falling clock edge |
| sdo_i | output | 1 | Data-in bit aligned with sck_rise_en_o |
| sdo_hiz_o | output | 1 | Forces the data-out driver to high impedance |
| paused_o | output | 1 | Pause state |
| state_reset_o | output | 1 | One-cycle request to clear the framer command state |

## Verification
Two functions can fall in the same cycle: a pause transition and a serial clock edge. Both are driven by the falling clock edge when a hold change has been deferred. The bench provokes this by moving hold_n_i while sck_i is high and then lowering the clock. It judges the result by the fall-strobe count, which must not change, and by the captured bit stream, which must resume at the right position. A second pairing is deselect during a pause: chip select rises at the same sample that ends the pause, and there must be exactly one reset pulse and no strobe.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  typedef enum logic {
    HS_RUN   = 1'b0,
    HS_PAUSE = 1'b1
  } hold_state_e;

  typedef struct packed {
    logic cs_n;
    logic sck;
    logic sdi;
    logic hold_n;
  } pin_bus_t;

  localparam int PIN_W = $bits(pin_bus_t);
  localparam pin_bus_t PIN_IDLE = '{cs_n: 1'b1, sck: 1'b0, sdi: 1'b0, hold_n: 1'b1};
endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int              STAGES = 2,
  parameter int              W      = 4,
  parameter logic [W-1:0]    RST    = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RST;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RST;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_hold_edge.sv
module spi_hold_edge #(
  parameter logic IDLE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= IDLE;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
  assign fall_o = ~lvl_i & lvl_q;
endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
  import spi_hold_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic hold_n_i,
  output logic paused_o,
  output logic paused_nxt_o,
  output logic drop_o
);
  hold_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (cs_n_i) begin
      state_d = HS_RUN;
    end else if (!sck_i) begin
      // transitions only while the serial clock is low; a high clock defers them
      state_d = hold_n_i ? HS_RUN : HS_PAUSE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= HS_RUN;
    else         state_q <= state_d;
  end

  assign paused_o     = (state_q == HS_PAUSE);
  assign paused_nxt_o = (state_d == HS_PAUSE);
  assign drop_o       = paused_o & cs_n_i;
endmodule

// File: rtl/spi_hold_pause.sv
module spi_hold_pause
  import spi_hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic sdi_i,
  input  logic hold_n_i,
  output logic sck_rise_en_o,
  output logic sck_fall_en_o,
  output logic sdo_i,
  output logic sdo_hiz_o,
  output logic paused_o,
  output logic state_reset_o
);
  pin_bus_t pin_raw, pin_s;
  logic     cs_n_s, sck_s, sdi_s, hold_n_s;
  logic     sck_rise, sck_fall;
  logic     paused, paused_nxt, drop;

  assign pin_raw = '{cs_n: cs_n_i, sck: sck_i, sdi: sdi_i, hold_n: hold_n_i};

  // one synchronizer for all pins keeps their samples coherent
  spi_hold_sync #(
    .STAGES (SYNC_STAGES),
    .W      (PIN_W),
    .RST    (PIN_IDLE)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_raw),
    .q_o    (pin_s)
  );

  assign cs_n_s   = pin_s.cs_n;
  assign sck_s    = pin_s.sck;
  assign sdi_s    = pin_s.sdi;
  assign hold_n_s = pin_s.hold_n;

  spi_hold_edge #(.IDLE(PIN_IDLE.sck)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (sck_s),
    .rise_o (sck_rise),
    .fall_o (sck_fall)
  );

  spi_hold_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_n_i       (cs_n_s),
    .sck_i        (sck_s),
    .hold_n_i     (hold_n_s),
    .paused_o     (paused),
    .paused_nxt_o (paused_nxt),
    .drop_o       (drop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_rise_en_o <= 1'b0;
      sck_fall_en_o <= 1'b0;
      sdo_i         <= 1'b0;
      sdo_hiz_o     <= 1'b1;
      state_reset_o <= 1'b0;
    end else begin
      sck_rise_en_o <= sck_rise & ~cs_n_s & ~paused;
      // a fall that enters or leaves a pause is swallowed
      sck_fall_en_o <= sck_fall & ~cs_n_s & ~paused & ~paused_nxt;
      sdo_i         <= sdi_s;
      sdo_hiz_o     <= cs_n_s | paused_nxt;
      state_reset_o <= drop;
    end
  end

  assign paused_o = paused;
endmodule

// File: rtl/spi_hold_pause_chk.sv
module spi_hold_pause_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_n_s,
  input logic sck_s,
  input logic sck_rise_en_o,
  input logic sck_fall_en_o,
  input logic sdo_hiz_o,
  input logic paused_o,
  input logic state_reset_o
);
  assert_pause_hiz_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused_o |-> sdo_hiz_o);

  assert_no_rise_in_pause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_rise_en_o |-> !$past(paused_o));

  assert_no_fall_at_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_fall_en_o |-> (!$past(paused_o) && !paused_o));

  assert_move_clk_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((paused_o != $past(paused_o)) && !$past(cs_n_s)) |-> !$past(sck_s));

  assert_entry_needs_cs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(paused_o) |-> !$past(cs_n_s));

  assert_drop_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_reset_o |-> ($past(paused_o) && !paused_o));

  assert_strobe_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sck_rise_en_o && sck_fall_en_o));
endmodule

bind spi_hold_pause spi_hold_pause_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cs_n_s        (cs_n_s),
  .sck_s         (sck_s),
  .sck_rise_en_o (sck_rise_en_o),
  .sck_fall_en_o (sck_fall_en_o),
  .sdo_hiz_o     (sdo_hiz_o),
  .paused_o      (paused_o),
  .state_reset_o (state_reset_o)
);

// File: tb/sim_spi_hold_pause.sv
`timescale 1ns/1ps
module sim_spi_hold_pause;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, hold_n = 1'b1;
  logic rise_en, fall_en, sdo, hiz, paused, sreset;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  int got_rise = 0, got_fall = 0, got_rst = 0;
  int exp_rise = 0, exp_fall = 0, exp_rst = 0;
  logic [7:0] got_cap = '0, exp_cap = '0;
  bit pm = 1'b0;

  always #2 clk = ~clk;

  spi_hold_pause u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .sck_i(sck), .sdi_i(sdi),
    .hold_n_i(hold_n), .sck_rise_en_o(rise_en), .sck_fall_en_o(fall_en),
    .sdo_i(sdo), .sdo_hiz_o(hiz), .paused_o(paused), .state_reset_o(sreset)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (rise_en) begin got_rise++; got_cap <= {got_cap[6:0], sdo}; end
      if (fall_en) got_fall++;
      if (sreset)  got_rst++;
    end
  end

  function automatic bit next_pause(bit c, bit k, bit h, bit p);
    if (c) return 1'b0;
    if (!k) return !h;
    return p;
  endfunction

  function automatic bit exp_hiz(bit c, bit p);
    return c | p;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic pins(bit c, bit k, bit d, bit h);
    bit pn;
    @(negedge clk);
    pn = next_pause(c, k, h, pm);
    if (!sck && k && !c && !pm) begin exp_rise++; exp_cap = {exp_cap[6:0], d}; end
    if (sck && !k && !c && !pm && !pn) exp_fall++;
    if (pm && c) exp_rst++;
    cs_n = c; sck = k; sdi = d; hold_n = h;
    pm = pn;
    repeat (8) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_state(string req);
    chk(paused == pm, req, paused, pm);
    chk(hiz == exp_hiz(cs_n, pm), req, hiz, exp_hiz(cs_n, pm));
  endtask

  task automatic send_bit(bit b);
    pins(cs_n, 1'b0, b, hold_n);
    pins(cs_n, 1'b1, b, hold_n);
    pins(cs_n, 1'b0, b, hold_n);
  endtask

  task automatic chk_counts(string req);
    chk(got_rise == exp_rise, req, got_rise, exp_rise);
    chk(got_fall == exp_fall, req, got_fall, exp_fall);
    chk(got_cap == exp_cap, req, got_cap, exp_cap);
    chk(got_rst == exp_rst, req, got_rst, exp_rst);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1
    chk(paused == 1'b0, "R1", paused, 0);
    chk(hiz == 1'b1, "R1", hiz, 1);
    chk(!rise_en && !fall_en && !sreset, "R1", {rise_en, fall_en, sreset}, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R6: hold ignored while deselected
    pins(1, 0, 0, 0);
    chk_state("R6");
    pins(1, 0, 0, 1);

    // R9/R8: plain byte
    pins(0, 0, 0, 1);
    chk_state("R8");
    for (int i = 7; i >= 0; i--) send_bit(8'hA5 >> i);
    chk_counts("R9");

    // R2/R5: pause in mid byte
    for (int i = 7; i >= 4; i--) send_bit(8'h3C >> i);
    pins(0, 0, sdi, 0);
    chk_state("R2");
    for (int i = 0; i < 5; i++) begin
      pins(0, 1, i[0], 0);
      pins(0, 0, !i[0], 0);
    end
    chk_counts("R5");
    pins(0, 0, sdi, 1);
    chk_state("R4");
    for (int i = 3; i >= 0; i--) send_bit(8'h3C >> i);
    chk_counts("R5");

    // R3/R4: deferred entry and exit on a high clock
    pins(0, 1, 1, 1);
    pins(0, 1, 1, 0);
    chk_state("R3");
    pins(0, 0, 1, 0);
    chk_state("R3");
    chk_counts("R3");
    pins(0, 1, 0, 0);
    pins(0, 1, 0, 1);
    chk_state("R4");
    pins(0, 0, 0, 1);
    chk_state("R4");
    chk_counts("R4");

    // R7: deselect during a pause, then without one
    pins(0, 0, 0, 0);
    pins(1, 0, 0, 0);
    chk_state("R7");
    chk_counts("R7");
    pins(1, 0, 0, 1);
    pins(0, 0, 0, 1);
    pins(1, 0, 0, 1);
    chk_counts("R7");

    // random traffic with pauses at random points
    for (int t = 0; t < 40; t++) begin
      logic [7:0] byte_v;
      byte_v = 8'($urandom);
      pins(0, 0, 0, 1);
      for (int i = 7; i >= 0; i--) begin
        if ($urandom_range(3) == 0) begin
          bit hi_clk;
          hi_clk = 1'($urandom);
          pins(0, hi_clk, sdi, 0);
          pins(0, 0, 1'($urandom), 0);
          chk_state("R2");
          pins(0, 1, 1'($urandom), 0);
          pins(0, 1, sdi, 1);
          pins(0, 0, sdi, 1);
          chk_state("R4");
        end
        send_bit(byte_v[i]);
      end
      chk_counts("R5");
      if (t % 8 == 7) begin
        pins(0, 0, 0, 0);
        pins(1, 0, 0, 0);
        chk_state("R7");
        pins(1, 0, 0, 1);
      end
    end
    pins(1, 0, 0, 1);
    chk_counts("R9");
    chk_state("R8");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule